// File: doc/BRIEF.md
# Speculative Load Conflict Log

This block keeps a small record of loads that a core has hoisted above stores it could not prove independent. Each speculative load leaves an entry naming its destination register, the word it read and the bytes of that word it covered. Stores search the record by address and strike out any entry whose bytes they overlap. When the core reaches the point where the hoisted load would originally have run, it issues a verify by destination register. If the entry is still there, the speculation held and nothing needs to happen. If it is gone, the core must either redo the load or, for the branch form of verify, jump to recovery code.

Loads and stores present word addresses with a per-byte lane mask, so a narrow store into part of a loaded word is caught even though the byte addresses differ. The log has a fixed number of entries. When it is full, a new speculative load displaces the entry that was recorded earliest, and a later verify for that load reports a conflict, which is always safe. All three request ports may be active in the same cycle. Their effects apply in a fixed order: first the store check, then the verify lookup, then the allocation.

Top module: `spec_load_log`

## Requirements
- R1: After reset the log is empty, so `rsp_valid` is low and the first verify for any register misses.
- R2: A speculative load records its register, word and lane mask. A later verify of that register with no conflict in between answers code 0 (no-op).
- R3: A speculative load discards every live entry that has the same destination register, so at most one live entry exists per register.
- R4: A store removes every live entry that has the same word address and whose lane mask shares at least one set bit with the store's lane mask. This includes a one-byte store into a fully loaded word.
- R5: A store to a different word, or to the same word with disjoint lanes, leaves the entry in place.
- R6: A load-verify (`vf_kind`=0) that finds no live entry answers code 1 (reissue load) and returns the recompute address on `rsp_addr`.
- R7: A branch-verify (`vf_kind`=1) that finds no live entry answers code 2 (take branch).
- R8: Every verify is answered exactly one cycle later, with `rsp_reg` echoing the verified register. No response appears without a verify.
- R9: A verify that finds its entry frees it, so a second verify of the same register misses.
- R10: With all DEPTH entries live and no entry freed in the cycle, a new speculative load evicts the entry allocated earliest. Other entries are kept.
- R11: When requests share a cycle, the store check applies before the verify lookup, and the verify lookup applies before the allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sl_valid | input | 1 | Speculative load request |
| sl_reg | input | REG_W | Destination register of the speculative load |
| sl_word | input | ADDR_W-2 | Word address read by the load |
| sl_mask | input | 4 | Byte lanes read within the word |
| st_valid | input | 1 | Store request |
| st_word | input | ADDR_W-2 | Word address written by the store |
| st_mask | input | 4 | Byte lanes written within the word |
| vf_valid | input | 1 | Verify request |
| vf_kind | input | 1 | 0 load-verify, 1 branch-verify |
| vf_reg | input | REG_W | Register being verified |
| vf_addr | input | ADDR_W | Recompute byte address for a reissued load |
| rsp_valid | output | 1 | Verify answer valid |
| rsp_code | output | 2 | 0 no-op, 1 reissue load, 2 take branch |
| rsp_reg | output | REG_W | Register of the answered verify |
| rsp_addr | output | ADDR_W | Recompute address of the answered verify |

## Verification
The log's contents can only be seen through verify answers. Each answer is registered once, so it appears on the outputs one cycle after the verify request. Stores and speculative loads change the entry state at the same clock edge, and a verify issued in the following cycle already sees that change. The bench drives each request on a falling edge and updates a reference model straight away, applying the same-cycle ordering. On the next falling edge, after the capturing rising edge, it compares the answer against the model's expectation. Directed sequences target partial overwrite, disjoint lanes, target cancellation, eviction and same-cycle collisions, and a seeded random phase over a small register and address space follows them.

// File: rtl/spec_log_pkg.sv
// Shared encodings for the speculative load conflict log.
package spec_log_pkg;
    // Verify answer codes as seen on rsp_code.
    typedef enum logic [1:0] {
        RSP_NOOP   = 2'd0,
        RSP_RELOAD = 2'd1,
        RSP_BRANCH = 2'd2
    } rsp_code_e;

    // Verify kinds as seen on vf_kind.
    localparam logic VK_LOAD   = 1'b0;
    localparam logic VK_BRANCH = 1'b1;
endpackage

// File: rtl/spec_log_cam.sv
// Associative compare stage: for each entry, flags store overlap
// (same word and shared byte lanes) and register equality against the
// verify and speculative-load ports. Assumes requests are qualified by
// their valid inputs here; entry validity is applied by the caller.
module spec_log_cam #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int WORD_W = 30,
    parameter int BYTES  = 4
) (
    input  logic [DEPTH-1:0][REG_W-1:0]  ent_reg,
    input  logic [DEPTH-1:0][WORD_W-1:0] ent_word,
    input  logic [DEPTH-1:0][BYTES-1:0]  ent_mask,
    input  logic                         st_valid,
    input  logic [WORD_W-1:0]            st_word,
    input  logic [BYTES-1:0]             st_mask,
    input  logic                         vf_valid,
    input  logic [REG_W-1:0]             vf_reg,
    input  logic                         sl_valid,
    input  logic [REG_W-1:0]             sl_reg,
    output logic [DEPTH-1:0]             st_kill,
    output logic [DEPTH-1:0]             vf_eq,
    output logic [DEPTH-1:0]             sl_eq
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Overlap needs the same word and at least one common lane.
        assign st_kill[g] = st_valid && (ent_word[g] == st_word) &&
                            (|(ent_mask[g] & st_mask));
        // Register lookups for the verify and allocate paths.
        assign vf_eq[g]   = vf_valid && (ent_reg[g] == vf_reg);
        assign sl_eq[g]   = sl_valid && (ent_reg[g] == sl_reg);
    end
endmodule

// File: rtl/spec_log_age.sv
// Age ranking: keeps, for every live entry, its rank in allocation order
// (0 = newest). Ranks are recompacted every cycle over the surviving
// entries so the earliest of a full log always carries rank DEPTH-1.
// Assumes the newly written slot is not part of keep.
module spec_log_age #(
    parameter int DEPTH = 8,
    localparam int AGE_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            keep,
    input  logic [DEPTH-1:0]            new_oh,
    output logic [DEPTH-1:0][AGE_W-1:0] age_q
);
    logic [DEPTH-1:0][AGE_W-1:0] age_d;
    logic                        alloc;

    assign alloc = |new_oh;

    for (genvar g = 0; g < DEPTH; g++) begin : g_rank
        logic [AGE_W-1:0] rank;
        // Count surviving entries younger than this one.
        always_comb begin
            rank = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != g && keep[j] && (age_q[j] < age_q[g])) begin
                    rank = rank + 1'b1;
                end
            end
            if (new_oh[g]) begin
                age_d[g] = '0;
            end else if (keep[g]) begin
                age_d[g] = rank + AGE_W'(alloc);
            end else begin
                age_d[g] = '0;
            end
        end
    end

    // Rank register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end
endmodule

// File: rtl/spec_log_pick.sv
// Slot choice for a new speculative load: lowest free slot if any,
// otherwise the entry of highest rank (earliest allocated). Assumes
// that when no slot is free, ranks of all entries are distinct.
module spec_log_pick #(
    parameter int DEPTH = 8,
    localparam int AGE_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]            free_v,
    input  logic [DEPTH-1:0][AGE_W-1:0] age_q,
    output logic [DEPTH-1:0]            slot_oh
);
    logic [DEPTH-1:0] lowest;
    logic [DEPTH-1:0] oldest;

    assign lowest = free_v & (~free_v + 1'b1);

    for (genvar g = 0; g < DEPTH; g++) begin : g_old
        assign oldest[g] = (age_q[g] == AGE_W'(DEPTH - 1));
    end

    // Prefer an empty slot; evict only when the log is full.
    always_comb begin
        slot_oh = (|free_v) ? lowest : oldest;
    end
endmodule

// File: rtl/spec_load_log.sv
// Speculative load conflict log top. Applies, within one cycle, the store
// overlap check, then the verify lookup (which frees a hit), then the
// allocation of a speculative load (which drops same-register entries and
// evicts the earliest entry when full). Verify answers are registered.
// Assumes 4-byte words addressed by word on the load and store ports.
module spec_load_log #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int ADDR_W = 32,
    localparam int BYTES  = 4,
    localparam int OFS_W  = $clog2(BYTES),
    localparam int WORD_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sl_valid,
    input  logic [REG_W-1:0]  sl_reg,
    input  logic [WORD_W-1:0] sl_word,
    input  logic [BYTES-1:0]  sl_mask,
    input  logic              st_valid,
    input  logic [WORD_W-1:0] st_word,
    input  logic [BYTES-1:0]  st_mask,
    input  logic              vf_valid,
    input  logic              vf_kind,
    input  logic [REG_W-1:0]  vf_reg,
    input  logic [ADDR_W-1:0] vf_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [REG_W-1:0]  rsp_reg,
    output logic [ADDR_W-1:0] rsp_addr
);
    import spec_log_pkg::*;
    localparam int AGE_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]             ent_vld;
    logic [DEPTH-1:0][REG_W-1:0]  ent_reg;
    logic [DEPTH-1:0][WORD_W-1:0] ent_word;
    logic [DEPTH-1:0][BYTES-1:0]  ent_mask;
    logic [DEPTH-1:0][AGE_W-1:0]  age_q;

    logic [DEPTH-1:0] st_kill, vf_eq, sl_eq;
    logic [DEPTH-1:0] after_st, vf_hit_v, after_vf, after_sl;
    logic [DEPTH-1:0] pick_oh, new_oh, keep;
    logic             vf_hit;

    spec_log_cam #(
        .DEPTH(DEPTH), .REG_W(REG_W), .WORD_W(WORD_W), .BYTES(BYTES)
    ) u_cam (
        .ent_reg(ent_reg), .ent_word(ent_word), .ent_mask(ent_mask),
        .st_valid(st_valid), .st_word(st_word), .st_mask(st_mask),
        .vf_valid(vf_valid), .vf_reg(vf_reg),
        .sl_valid(sl_valid), .sl_reg(sl_reg),
        .st_kill(st_kill), .vf_eq(vf_eq), .sl_eq(sl_eq)
    );

    // Ordered application of the three requests within the cycle.
    always_comb begin
        after_st = ent_vld & ~st_kill;
        vf_hit_v = after_st & vf_eq;
        vf_hit   = |vf_hit_v;
        after_vf = after_st & ~vf_hit_v;
        after_sl = after_vf & ~sl_eq;
        new_oh   = sl_valid ? pick_oh : '0;
        keep     = after_sl & ~new_oh;
    end

    spec_log_pick #(.DEPTH(DEPTH)) u_pick (
        .free_v(~after_sl), .age_q(age_q), .slot_oh(pick_oh)
    );

    spec_log_age #(.DEPTH(DEPTH)) u_age (
        .clk(clk), .rst_n(rst_n), .keep(keep), .new_oh(new_oh), .age_q(age_q)
    );

    // Entry storage: validity and the fields of newly written slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld  <= '0;
            ent_reg  <= '0;
            ent_word <= '0;
            ent_mask <= '0;
        end else begin
            ent_vld <= keep | new_oh;
            for (int i = 0; i < DEPTH; i++) begin
                if (new_oh[i]) begin
                    ent_reg[i]  <= sl_reg;
                    ent_word[i] <= sl_word;
                    ent_mask[i] <= sl_mask;
                end
            end
        end
    end

    // Registered verify answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_NOOP;
            rsp_reg   <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= vf_valid;
            rsp_reg   <= vf_reg;
            rsp_addr  <= vf_addr;
            if (vf_hit) begin
                rsp_code <= RSP_NOOP;
            end else if (vf_kind == VK_BRANCH) begin
                rsp_code <= RSP_BRANCH;
            end else begin
                rsp_code <= RSP_RELOAD;
            end
        end
    end
endmodule

// File: rtl/spec_load_log_chk.sv
// Property checker for spec_load_log, bound to every instance.
module spec_load_log_chk #(
    parameter int DEPTH = 8,
    parameter int REG_W = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sl_valid,
    input logic [REG_W-1:0]           sl_reg,
    input logic                       vf_valid,
    input logic                       vf_kind,
    input logic                       rsp_valid,
    input logic [1:0]                 rsp_code,
    input logic [DEPTH-1:0]           ent_vld,
    input logic [DEPTH-1:0][REG_W-1:0] ent_reg
);
    logic [REG_W-1:0] prev_sl_reg;
    logic [DEPTH-1:0] prev_eq;

    // Remember the last allocated register for the allocation check.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_sl_reg <= '0;
        else        prev_sl_reg <= sl_reg;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_eq
        assign prev_eq[g] = (ent_reg[g] == prev_sl_reg);
    end

    // R8: an answer follows each verify, and only a verify.
    a_r8_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        vf_valid |=> rsp_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !vf_valid |=> !rsp_valid);
    // R6: a load-verify never answers take-branch.
    a_r6_load_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_valid && !vf_kind) |=> (rsp_code != 2'd2));
    // R7: a branch-verify never answers reissue-load.
    a_r7_branch_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_valid && vf_kind) |=> (rsp_code != 2'd1));
    // R2: a speculative load leaves a live entry for its register.
    a_r2_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        sl_valid |=> (|(ent_vld & prev_eq)));

    // R3: never two live entries for one register.
    for (genvar i = 0; i < DEPTH; i++) begin : g_pi
        for (genvar j = i + 1; j < DEPTH; j++) begin : g_pj
            a_r3_unique_reg: assert property (@(posedge clk) disable iff (!rst_n)
                !(ent_vld[i] && ent_vld[j] && (ent_reg[i] == ent_reg[j])));
        end
    end
endmodule

bind spec_load_log spec_load_log_chk #(.DEPTH(DEPTH), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sl_valid(sl_valid), .sl_reg(sl_reg),
    .vf_valid(vf_valid), .vf_kind(vf_kind), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .ent_vld(ent_vld), .ent_reg(ent_reg)
);

// File: tb/spec_load_log_bench.sv
`timescale 1ns/1ps
module spec_load_log_bench;
    localparam int DEPTH  = 8;
    localparam int REG_W  = 5;
    localparam int ADDR_W = 32;
    localparam int WORD_W = ADDR_W - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sl_valid = 0, st_valid = 0, vf_valid = 0, vf_kind = 0;
    logic [REG_W-1:0]  sl_reg = '0, vf_reg = '0;
    logic [WORD_W-1:0] sl_word = '0, st_word = '0;
    logic [3:0]        sl_mask = '0, st_mask = '0;
    logic [ADDR_W-1:0] vf_addr = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_code;
    logic [REG_W-1:0]  rsp_reg;
    logic [ADDR_W-1:0] rsp_addr;

    spec_load_log #(.DEPTH(DEPTH), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_spec_load_log (
        .clk(clk), .rst_n(rst_n),
        .sl_valid(sl_valid), .sl_reg(sl_reg), .sl_word(sl_word), .sl_mask(sl_mask),
        .st_valid(st_valid), .st_word(st_word), .st_mask(st_mask),
        .vf_valid(vf_valid), .vf_kind(vf_kind), .vf_reg(vf_reg), .vf_addr(vf_addr),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_reg(rsp_reg), .rsp_addr(rsp_addr)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    // Reference model of the log.
    bit                m_v[DEPTH];
    logic [REG_W-1:0]  m_reg[DEPTH];
    logic [WORD_W-1:0] m_word[DEPTH];
    logic [3:0]        m_mask[DEPTH];
    int                m_stamp[DEPTH];
    int                stamp = 0;

    // Pending expectation for the next falling edge.
    bit                pend = 0, e_vv = 0;
    logic [1:0]        e_code = 0;
    logic [REG_W-1:0]  e_reg = 0;
    logic [ADDR_W-1:0] e_addr = 0;
    string             e_tag = "";

    task automatic check_pending();
        if (!pend) return;
        checks++;
        if (!e_vv) begin
            if (rsp_valid !== 1'b0) begin
                fails++;
                $display("FAIL %s: rsp_valid=%0b expected 0", e_tag, rsp_valid);
            end
        end else if (rsp_valid !== 1'b1 || rsp_code !== e_code ||
                     rsp_reg !== e_reg || rsp_addr !== e_addr) begin
            fails++;
            $display("FAIL %s: valid=%0b code=%0d reg=%0d addr=%h expected 1 code=%0d reg=%0d addr=%h",
                     e_tag, rsp_valid, rsp_code, rsp_reg, rsp_addr, e_code, e_reg, e_addr);
        end
    endtask

    // One cycle: check last answer, drive requests, advance the model
    // in the order store, verify, allocate (R11).
    task automatic step(input bit lv, input int lr, input int la, input int lm,
                        input bit sv, input int sa, input int sm,
                        input bit vv, input bit vk, input int vr, input int va,
                        input string tag);
        int hit, cnt, old, slot;
        @(negedge clk);
        check_pending();
        sl_valid = lv; sl_reg = REG_W'(lr); sl_word = WORD_W'(la >> 2); sl_mask = 4'(lm);
        st_valid = sv; st_word = WORD_W'(sa >> 2); st_mask = 4'(sm);
        vf_valid = vv; vf_kind = vk; vf_reg = REG_W'(vr); vf_addr = ADDR_W'(va);
        if (sv) begin
            for (int i = 0; i < DEPTH; i++)
                if (m_v[i] && m_word[i] == st_word && (m_mask[i] & st_mask) != 0) m_v[i] = 0;
        end
        e_vv = vv; e_reg = vf_reg; e_addr = vf_addr; e_tag = tag; pend = 1;
        if (vv) begin
            hit = -1;
            for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_reg[i] == vf_reg) hit = i;
            if (hit >= 0) begin e_code = 2'd0; m_v[hit] = 0; end
            else e_code = vk ? 2'd2 : 2'd1;
        end
        if (lv) begin
            cnt = 0; old = -1;
            for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_reg[i] == sl_reg) m_v[i] = 0;
            for (int i = 0; i < DEPTH; i++) if (m_v[i]) begin
                cnt++;
                if (old < 0 || m_stamp[i] < m_stamp[old]) old = i;
            end
            if (cnt == DEPTH) m_v[old] = 0;
            slot = -1;
            for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            m_v[slot] = 1; m_reg[slot] = sl_reg; m_word[slot] = sl_word;
            m_mask[slot] = sl_mask; m_stamp[slot] = stamp; stamp++;
        end
    endtask

    task automatic ld(input int r, input int a, input int m, input string t);
        step(1, r, a, m, 0, 0, 0, 0, 0, 0, 0, t);
    endtask
    task automatic st(input int a, input int m, input string t);
        step(0, 0, 0, 0, 1, a, m, 0, 0, 0, 0, t);
    endtask
    task automatic vf(input bit k, input int r, input int a, input string t);
        step(0, 0, 0, 0, 0, 0, 0, 1, k, r, a, t);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        checks++; fails++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_stamp[i] = 0; end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset, no answer pending.
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++; $display("FAIL R1: rsp_valid=%0b expected 0", rsp_valid);
        end
        vf(0, 3, 'h500, "R1");
        // R2 hit then R9 free; R6 reissue address.
        ld(1, 'h100, 'hf, "R8");
        vf(0, 1, 'h200, "R2");
        vf(0, 1, 'h204, "R9");
        // R4 partial overwrite.
        ld(2, 'h104, 'hf, "R8");
        st('h107, 'h8, "R8");
        vf(0, 2, 'h104, "R4");
        // R5 disjoint lanes and other word.
        ld(3, 'h108, 'h3, "R8");
        st('h108, 'hc, "R8");
        st('h10c, 'hf, "R8");
        vf(0, 3, 'h108, "R5");
        // R3 same target cancels older entry.
        ld(4, 'h110, 'hf, "R8");
        ld(4, 'h120, 'hf, "R8");
        st('h110, 'hf, "R8");
        vf(0, 4, 'h120, "R3");
        ld(4, 'h110, 'hf, "R8");
        ld(4, 'h120, 'hf, "R8");
        st('h120, 'hf, "R8");
        vf(0, 4, 'h120, "R3");
        // R7 branch-verify miss and hit.
        vf(1, 9, 'h300, "R7");
        ld(9, 'h130, 'hf, "R8");
        vf(1, 9, 'h300, "R7");
        // R10 eviction of earliest entry.
        for (int k = 0; k < DEPTH + 1; k++) ld(10 + k, 'h400 + 4 * k, 'hf, "R8");
        vf(0, 10, 'h400, "R10");
        vf(0, 11, 'h404, "R10");
        // R11 same-cycle orderings.
        step(1, 5, 'h140, 'hf, 1, 'h140, 'hf, 0, 0, 0, 0, "R11");
        vf(0, 5, 'h140, "R11");
        ld(6, 'h150, 'hf, "R8");
        step(0, 0, 0, 0, 1, 'h150, 'h1, 1, 0, 6, 'h150, "R11");
        step(1, 7, 'h160, 'hf, 0, 0, 0, 1, 0, 7, 'h160, "R11");
        vf(0, 7, 'h160, "R11");
        // Random phase over a small register and address space.
        for (int n = 0; n < 4000; n++) begin
            step($urandom % 2 == 0, $urandom % 12, 'h40 + 4 * ($urandom % 8), ($urandom % 15) + 1,
                 $urandom % 3 == 0, 'h40 + 4 * ($urandom % 8), ($urandom % 15) + 1,
                 $urandom % 2 == 0, $urandom % 2 == 1, $urandom % 12, $urandom,
                 "R8");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        @(negedge clk);
        check_pending();
        finish_run();
    end
endmodule